// File: doc/BRIEF.md
# Rename Map and Circular Dispatch Window

This block sits between decode and the execution units of an out-of-order core. Each decoded instruction takes the slot at the allocation pointer of a circular window. Its two source registers are looked up in a rename map, which returns either a finished value or the slot tag of the instruction that will produce it. The destination register is then remapped to the new slot's tag, so later readers wait on this instruction and not on an older writer.

Every cycle the window picks at most one slot that holds a live instruction, has not yet started, and has both operand values. The choice is the oldest such slot, counted from the retire pointer. That instruction goes out on the issue port with its opcode and operand values. Execution units report results as a (tag, data) pair. The window uses that pair to fill every waiting operand that carries the tag, to restore rename entries that still point at it, and to free the producing slot. The retire pointer steps forward one slot per cycle, and only over slots that have already been freed. A slot's tag becomes reusable once the retire pointer has passed it.

Top module: `ooo_window`

## Requirements
- R1: After a synchronous reset the window is empty: in_ready is 1, in_tag is 0, and issue_valid and retire_valid are 0. Architectural register r holds the value r and is marked present.
- R2: When in_valid is high and in_ready is high, the instruction is written into the slot numbered in_tag. in_tag then advances by one, wrapping modulo the slot count.
- R3: A source whose map entry is present reads that entry's value. A source that has been renamed reads the producer's tag and waits. If a completion for that tag arrives in the same cycle as the allocation, the source takes the completed data at once.
- R4: Allocation maps the destination register to the new slot's tag and marks it not present. A source of the same instruction that names the same register still reads the older mapping.
- R5: A slot issues only when it is live, not yet started, and both operands are present. It issues exactly once. issue_tag, issue_op, issue_a and issue_b give its slot number, opcode and operand values.
- R6: When several slots are ready, the one issued is the first one found walking forward from the retire pointer, with wraparound.
- R7: A completion (done_valid, done_tag, done_data) writes done_data into every waiting source operand holding done_tag and marks it present.
- R8: A completion frees slot done_tag. The retire pointer retires one slot per cycle (retire_valid, retire_tag), and only when the slot it points at is occupied and freed. A freed slot behind a busy older slot waits.
- R9: A rename map entry takes a completion's data only if it still holds that tag. An allocation that renames the same register in the same cycle wins, and a present entry changes only through a rename.
- R10: With all slots occupied, in_ready is 0 and an offered instruction is ignored: no slot is written, no register is renamed, and in_tag stays put.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction offered |
| in_op | input | OP_W | Opcode of the offered instruction |
| in_src_a | input | AREG_W | First source register |
| in_src_b | input | AREG_W | Second source register |
| in_dst | input | AREG_W | Destination register |
| in_ready | output | 1 | A free slot exists |
| in_tag | output | TAG_W | Slot the next instruction will take |
| issue_valid | output | 1 | A slot is starting execution this cycle |
| issue_tag | output | TAG_W | Slot number of the issuing instruction |
| issue_op | output | OP_W | Opcode of the issuing instruction |
| issue_a | output | DATA_W | First operand value |
| issue_b | output | DATA_W | Second operand value |
| done_valid | input | 1 | A result is being broadcast |
| done_tag | input | TAG_W | Slot that produced the result |
| done_data | input | DATA_W | Result value |
| retire_valid | output | 1 | The oldest slot leaves the window this cycle |
| retire_tag | output | TAG_W | Slot being retired |

## Verification
The assertions check, on every cycle, the rules that hold locally. Occupancy never goes past the slot count, and in_tag does not move while the window is full. An issued slot is ready when it issues and never ready again afterwards. A completed slot is no longer live on the next cycle, retirement walks the tags in order, a renamed entry is not present, and a present map entry changes only through a rename. Some behaviours need a planned sequence of instructions before they show at the ports, so only the bench's scenarios can show them. These are the same-cycle completion bypass, a younger rename surviving an older completion, oldest-first choice across the wrap point, in-order retirement behind a slower older slot, and an offer that is ignored while the window is full.

// File: rtl/ooo_pkg.sv
package ooo_pkg;

    parameter int NUM_AREGS = 8;
    parameter int NUM_SLOTS = 8;   // power of two
    parameter int DATA_W    = 16;
    parameter int OP_W      = 4;

    localparam int AREG_W = $clog2(NUM_AREGS);
    localparam int TAG_W  = $clog2(NUM_SLOTS);
    localparam int CNT_W  = $clog2(NUM_SLOTS + 1);

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [AREG_W-1:0] areg_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [OP_W-1:0]   op_t;

    // Operand: present -> payload is a value, else low bits are a producer tag.
    typedef struct packed {
        logic  present;
        data_t payload;
    } opnd_t;

    typedef struct packed {
        logic  live;
        logic  started;
        op_t   op;
        opnd_t sa;
        opnd_t sb;
    } slot_t;

    function automatic tag_t tag_of(opnd_t o);
        return o.payload[TAG_W-1:0];
    endfunction

    function automatic logic opnd_hit(opnd_t o, logic v, tag_t t);
        return v && !o.present && (tag_of(o) == t);
    endfunction

    function automatic opnd_t opnd_fill(opnd_t o, logic v, tag_t t, data_t d);
        opnd_t r;
        r = o;
        if (opnd_hit(o, v, t)) begin
            r.present = 1'b1;
            r.payload = d;
        end
        return r;
    endfunction

endpackage

// File: rtl/ooo_rename_map.sv
module ooo_rename_map
    import ooo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  areg_t rd_a_idx,
    input  areg_t rd_b_idx,
    output opnd_t rd_a,
    output opnd_t rd_b,
    input  logic  ren_en,
    input  areg_t ren_idx,
    input  tag_t  ren_tag,
    input  logic  bc_valid,
    input  tag_t  bc_tag,
    input  data_t bc_data
);

    opnd_t map_q [NUM_AREGS];

    // Reads see a completion arriving in the same cycle.
    assign rd_a = opnd_fill(map_q[rd_a_idx], bc_valid, bc_tag, bc_data);
    assign rd_b = opnd_fill(map_q[rd_b_idx], bc_valid, bc_tag, bc_data);

    always_ff @(posedge clk) begin
        for (int r = 0; r < NUM_AREGS; r++) begin
            if (rst) begin
                map_q[r].present <= 1'b1;
                map_q[r].payload <= DATA_W'(r);
            end else if (ren_en && ren_idx == areg_t'(r)) begin
                map_q[r].present <= 1'b0;
                map_q[r].payload <= DATA_W'(ren_tag);
            end else begin
                map_q[r] <= opnd_fill(map_q[r], bc_valid, bc_tag, bc_data);
            end
        end
    end

    // R4: a freshly renamed register waits on its producer.
    assert_renamed_pending_R4: assert property (@(posedge clk) disable iff (rst)
        ren_en |=> !map_q[$past(ren_idx)].present);

    for (genvar g = 0; g < NUM_AREGS; g++) begin : g_keep
        // R9: a present entry is only ever changed by a rename.
        assert_value_kept_R9: assert property (@(posedge clk) disable iff (rst)
            (map_q[g].present && !(ren_en && ren_idx == areg_t'(g)))
            |=> (map_q[g] == $past(map_q[g])));
    end

endmodule

// File: rtl/ooo_slot_store.sv
module ooo_slot_store
    import ooo_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  tag_t                 wr_idx,
    input  op_t                  wr_op,
    input  opnd_t                wr_sa,
    input  opnd_t                wr_sb,
    input  logic                 go_en,
    input  tag_t                 go_idx,
    input  logic                 bc_valid,
    input  tag_t                 bc_tag,
    input  data_t                bc_data,
    output logic [NUM_SLOTS-1:0] ready_vec,
    output logic [NUM_SLOTS-1:0] live_vec,
    output op_t                  go_op,
    output data_t                go_a,
    output data_t                go_b
);

    slot_t slot_q [NUM_SLOTS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rst) begin
                slot_q[i].live    <= 1'b0;
                slot_q[i].started <= 1'b0;
                slot_q[i].op      <= '0;
                slot_q[i].sa      <= '0;
                slot_q[i].sb      <= '0;
            end else if (wr_en && wr_idx == tag_t'(i)) begin
                slot_q[i].live    <= 1'b1;
                slot_q[i].started <= 1'b0;
                slot_q[i].op      <= wr_op;
                slot_q[i].sa      <= wr_sa;
                slot_q[i].sb      <= wr_sb;
            end else begin
                if (go_en && go_idx == tag_t'(i))
                    slot_q[i].started <= 1'b1;
                if (bc_valid && bc_tag == tag_t'(i))
                    slot_q[i].live <= 1'b0;
                slot_q[i].sa <= opnd_fill(slot_q[i].sa, bc_valid, bc_tag, bc_data);
                slot_q[i].sb <= opnd_fill(slot_q[i].sb, bc_valid, bc_tag, bc_data);
            end
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_flags
        assign live_vec[g]  = slot_q[g].live;
        assign ready_vec[g] = slot_q[g].live && !slot_q[g].started
                              && slot_q[g].sa.present && slot_q[g].sb.present;
    end

    assign go_op = slot_q[go_idx].op;
    assign go_a  = slot_q[go_idx].sa.payload;
    assign go_b  = slot_q[go_idx].sb.payload;

    // R5: the picker only grants ready slots, and a slot issues once.
    assert_issue_ready_R5: assert property (@(posedge clk) disable iff (rst)
        go_en |-> ready_vec[go_idx]);
    assert_issue_once_R5: assert property (@(posedge clk) disable iff (rst)
        go_en |=> !ready_vec[$past(go_idx)]);
    // R8: a completion frees its slot.
    assert_done_frees_R8: assert property (@(posedge clk) disable iff (rst)
        bc_valid |=> !live_vec[$past(bc_tag)]);

endmodule

// File: rtl/ooo_age_picker.sv
module ooo_age_picker
    import ooo_pkg::*;
(
    input  logic [NUM_SLOTS-1:0] req,
    input  tag_t                 base,
    output logic                 grant_valid,
    output tag_t                 grant_idx
);

    always_comb begin
        tag_t cand;
        grant_valid = 1'b0;
        grant_idx   = base;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            cand = base + tag_t'(k);
            if (!grant_valid && req[cand]) begin
                grant_valid = 1'b1;
                grant_idx   = cand;
            end
        end
    end

endmodule

// File: rtl/ooo_window.sv
module ooo_window
    import ooo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [AREG_W-1:0] in_src_a,
    input  logic [AREG_W-1:0] in_src_b,
    input  logic [AREG_W-1:0] in_dst,
    output logic              in_ready,
    output logic [TAG_W-1:0]  in_tag,
    output logic              issue_valid,
    output logic [TAG_W-1:0]  issue_tag,
    output logic [OP_W-1:0]   issue_op,
    output logic [DATA_W-1:0] issue_a,
    output logic [DATA_W-1:0] issue_b,
    input  logic              done_valid,
    input  logic [TAG_W-1:0]  done_tag,
    input  logic [DATA_W-1:0] done_data,
    output logic              retire_valid,
    output logic [TAG_W-1:0]  retire_tag
);

    tag_t             alloc_ptr;
    tag_t             free_ptr;
    logic [CNT_W-1:0] occ_q;

    logic [NUM_SLOTS-1:0] ready_vec;
    logic [NUM_SLOTS-1:0] live_vec;
    opnd_t                src_a_lk;
    opnd_t                src_b_lk;
    logic                 alloc_fire;
    logic                 retire_fire;
    logic                 full;

    assign full        = (occ_q == CNT_W'(NUM_SLOTS));
    assign alloc_fire  = in_valid && !full;
    assign retire_fire = (occ_q != '0) && !live_vec[free_ptr];

    ooo_rename_map u_map (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (in_src_a),
        .rd_b_idx (in_src_b),
        .rd_a     (src_a_lk),
        .rd_b     (src_b_lk),
        .ren_en   (alloc_fire),
        .ren_idx  (in_dst),
        .ren_tag  (alloc_ptr),
        .bc_valid (done_valid),
        .bc_tag   (done_tag),
        .bc_data  (done_data)
    );

    ooo_age_picker u_pick (
        .req         (ready_vec),
        .base        (free_ptr),
        .grant_valid (issue_valid),
        .grant_idx   (issue_tag)
    );

    ooo_slot_store u_slots (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (alloc_fire),
        .wr_idx    (alloc_ptr),
        .wr_op     (in_op),
        .wr_sa     (src_a_lk),
        .wr_sb     (src_b_lk),
        .go_en     (issue_valid),
        .go_idx    (issue_tag),
        .bc_valid  (done_valid),
        .bc_tag    (done_tag),
        .bc_data   (done_data),
        .ready_vec (ready_vec),
        .live_vec  (live_vec),
        .go_op     (issue_op),
        .go_a      (issue_a),
        .go_b      (issue_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            alloc_ptr <= '0;
            free_ptr  <= '0;
            occ_q     <= '0;
        end else begin
            if (alloc_fire)
                alloc_ptr <= alloc_ptr + 1'b1;
            if (retire_fire)
                free_ptr <= free_ptr + 1'b1;
            occ_q <= occ_q + CNT_W'(alloc_fire) - CNT_W'(retire_fire);
        end
    end

    assign in_ready     = !full;
    assign in_tag       = alloc_ptr;
    assign retire_valid = retire_fire;
    assign retire_tag   = free_ptr;

    // R10: occupancy bounded, and a full window does not move its allocation point.
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        occ_q <= CNT_W'(NUM_SLOTS));
    assert_full_holds_tag_R10: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> $stable(in_tag));
    // R8: retirement visits tags in order.
    assert_retire_order_R8: assert property (@(posedge clk) disable iff (rst)
        retire_valid |=> (retire_tag == TAG_W'($past(retire_tag) + 1'b1)));

endmodule

// File: tb/test_ooo_window.sv
module test_ooo_window;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  in_op;
    logic [2:0]  in_src_a, in_src_b, in_dst;
    logic        in_ready;
    logic [2:0]  in_tag;
    logic        issue_valid;
    logic [2:0]  issue_tag;
    logic [3:0]  issue_op;
    logic [15:0] issue_a, issue_b;
    logic        done_valid;
    logic [2:0]  done_tag;
    logic [15:0] done_data;
    logic        retire_valid;
    logic [2:0]  retire_tag;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ooo_window i_ooo_window (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_op(in_op), .in_src_a(in_src_a),
        .in_src_b(in_src_b), .in_dst(in_dst),
        .in_ready(in_ready), .in_tag(in_tag),
        .issue_valid(issue_valid), .issue_tag(issue_tag), .issue_op(issue_op),
        .issue_a(issue_a), .issue_b(issue_b),
        .done_valid(done_valid), .done_tag(done_tag), .done_data(done_data),
        .retire_valid(retire_valid), .retire_tag(retire_tag)
    );

    typedef struct packed {
        logic        av;  logic [3:0] aop; logic [2:0] asa; logic [2:0] asb; logic [2:0] ad;
        logic        cv;  logic [2:0] ct;  logic [15:0] cd;
        logic        edv; logic [2:0] edt; logic [3:0] edo; logic [15:0] eda; logic [15:0] edb;
        logic        erv; logic [2:0] ert; logic ear; logic [2:0] eat;
    } vec_t;

    // One entry per cycle: drive, then expected outputs of that cycle.
    localparam vec_t VECS [0:14] = '{
        '{1'b1,4'd1,3'd1,3'd2,3'd3, 1'b0,3'd0,16'h0000, 1'b0,3'd0,4'd0,16'h0000,16'h0000, 1'b0,3'd0,1'b1,3'd0},
        '{1'b1,4'd2,3'd3,3'd4,3'd5, 1'b0,3'd0,16'h0000, 1'b1,3'd0,4'd1,16'h0001,16'h0002, 1'b0,3'd0,1'b1,3'd1},
        '{1'b1,4'd3,3'd5,3'd3,3'd3, 1'b1,3'd0,16'h0AAA, 1'b0,3'd0,4'd0,16'h0000,16'h0000, 1'b0,3'd0,1'b1,3'd2},
        '{1'b0,4'd0,3'd0,3'd0,3'd0, 1'b0,3'd0,16'h0000, 1'b1,3'd1,4'd2,16'h0AAA,16'h0004, 1'b1,3'd0,1'b1,3'd3},
        '{1'b0,4'd0,3'd0,3'd0,3'd0, 1'b1,3'd1,16'h0BBB, 1'b0,3'd0,4'd0,16'h0000,16'h0000, 1'b0,3'd0,1'b1,3'd3},
        '{1'b1,4'd4,3'd5,3'd3,3'd5, 1'b0,3'd0,16'h0000, 1'b1,3'd2,4'd3,16'h0BBB,16'h0AAA, 1'b1,3'd1,1'b1,3'd3},
        '{1'b1,4'd5,3'd3,3'd0,3'd6, 1'b1,3'd2,16'h0CCC, 1'b0,3'd0,4'd0,16'h0000,16'h0000, 1'b0,3'd0,1'b1,3'd4},
        '{1'b0,4'd0,3'd0,3'd0,3'd0, 1'b0,3'd0,16'h0000, 1'b1,3'd3,4'd4,16'h0BBB,16'h0CCC, 1'b1,3'd2,1'b1,3'd5},
        '{1'b0,4'd0,3'd0,3'd0,3'd0, 1'b0,3'd0,16'h0000, 1'b1,3'd4,4'd5,16'h0CCC,16'h0000, 1'b0,3'd0,1'b1,3'd5},
        '{1'b0,4'd0,3'd0,3'd0,3'd0, 1'b1,3'd4,16'h0DDD, 1'b0,3'd0,4'd0,16'h0000,16'h0000, 1'b0,3'd0,1'b1,3'd5},
        '{1'b0,4'd0,3'd0,3'd0,3'd0, 1'b1,3'd3,16'h0EEE, 1'b0,3'd0,4'd0,16'h0000,16'h0000, 1'b0,3'd0,1'b1,3'd5},
        '{1'b0,4'd0,3'd0,3'd0,3'd0, 1'b0,3'd0,16'h0000, 1'b0,3'd0,4'd0,16'h0000,16'h0000, 1'b1,3'd3,1'b1,3'd5},
        '{1'b0,4'd0,3'd0,3'd0,3'd0, 1'b0,3'd0,16'h0000, 1'b0,3'd0,4'd0,16'h0000,16'h0000, 1'b1,3'd4,1'b1,3'd5},
        '{1'b1,4'd6,3'd5,3'd6,3'd7, 1'b0,3'd0,16'h0000, 1'b0,3'd0,4'd0,16'h0000,16'h0000, 1'b0,3'd0,1'b1,3'd5},
        '{1'b0,4'd0,3'd0,3'd0,3'd0, 1'b0,3'd0,16'h0000, 1'b1,3'd5,4'd6,16'h0EEE,16'h0DDD, 1'b0,3'd0,1'b1,3'd6}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic av, input logic [3:0] op, input logic [2:0] sa,
                         input logic [2:0] sb, input logic [2:0] d, input logic cv,
                         input logic [2:0] ct, input logic [15:0] cd);
        @(negedge clk);
        in_valid = av; in_op = op; in_src_a = sa; in_src_b = sb; in_dst = d;
        done_valid = cv; done_tag = ct; done_data = cd;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0; in_op = '0; in_src_a = '0; in_src_b = '0; in_dst = '0;
        done_valid = 1'b0; done_tag = '0; done_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        #1;
        // R1: empty window after reset
        chk("R1", "in_ready", 32'(in_ready), 32'd1);
        chk("R1", "in_tag", 32'(in_tag), 32'd0);
        chk("R1", "issue_valid", 32'(issue_valid), 32'd0);
        chk("R1", "retire_valid", 32'(retire_valid), 32'd0);

        // Table walk: R1 reset values, R2 tags, R3 bypass, R4 rename, R5 issue,
        // R6 oldest pick, R7 broadcast fill, R8 in-order retire, R9 younger rename kept.
        for (int k = 0; k < 15; k++) begin
            vec_t v;
            v = VECS[k];
            drive(v.av, v.aop, v.asa, v.asb, v.ad, v.cv, v.ct, v.cd);
            chk("R2", $sformatf("vec%0d in_tag", k), 32'(in_tag), 32'(v.eat));
            chk("R10", $sformatf("vec%0d in_ready", k), 32'(in_ready), 32'(v.ear));
            chk("R5", $sformatf("vec%0d issue_valid", k), 32'(issue_valid), 32'(v.edv));
            if (v.edv) begin
                chk("R6", $sformatf("vec%0d issue_tag", k), 32'(issue_tag), 32'(v.edt));
                chk("R5", $sformatf("vec%0d issue_op", k), 32'(issue_op), 32'(v.edo));
                chk("R7", $sformatf("vec%0d issue_a", k), 32'(issue_a), 32'(v.eda));
                chk("R3", $sformatf("vec%0d issue_b", k), 32'(issue_b), 32'(v.edb));
            end
            chk("R8", $sformatf("vec%0d retire_valid", k), 32'(retire_valid), 32'(v.erv));
            if (v.erv)
                chk("R8", $sformatf("vec%0d retire_tag", k), 32'(retire_tag), 32'(v.ert));
        end

        // Directed: fill the window, ignored offer when full, wrap-around age order.
        do_reset();
        for (int k = 0; k < 8; k++) begin
            drive(1'b1, 4'(k), (k == 7) ? 3'd0 : 3'd1, 3'd2, 3'd0, 1'b0, 3'd0, 16'h0);
            chk("R2", $sformatf("fill%0d in_tag", k), 32'(in_tag), 32'(k));
            chk("R10", $sformatf("fill%0d in_ready", k), 32'(in_ready), 32'd1);
            if (k > 0)
                chk("R5", $sformatf("fill%0d issue_tag", k), 32'(issue_tag), 32'(k - 1));
        end
        drive(1'b1, 4'hF, 3'd7, 3'd7, 3'd7, 1'b0, 3'd0, 16'h0);
        chk("R10", "full in_ready", 32'(in_ready), 32'd0);
        chk("R5", "slot7 waits on r0", 32'(issue_valid), 32'd0);
        drive(1'b0, 4'h0, 3'd0, 3'd0, 3'd0, 1'b1, 3'd0, 16'h1234);
        chk("R10", "tag held while full", 32'(in_tag), 32'd0);
        drive(1'b0, 4'h0, 3'd0, 3'd0, 3'd0, 1'b0, 3'd0, 16'h0);
        chk("R8", "retire slot0 valid", 32'(retire_valid), 32'd1);
        chk("R8", "retire slot0 tag", 32'(retire_tag), 32'd0);
        drive(1'b1, 4'd9, 3'd7, 3'd2, 3'd1, 1'b1, 3'd6, 16'h0666);
        chk("R10", "space after retire", 32'(in_ready), 32'd1);
        chk("R2", "wrapped in_tag", 32'(in_tag), 32'd0);
        drive(1'b0, 4'h0, 3'd0, 3'd0, 3'd0, 1'b0, 3'd0, 16'h0);
        chk("R6", "older slot7 first", 32'(issue_tag), 32'd7);
        chk("R7", "slot7 filled", 32'(issue_a), 32'h0666);
        chk("R5", "slot7 op", 32'(issue_op), 32'd7);
        chk("R8", "no retire behind busy slot1", 32'(retire_valid), 32'd0);
        drive(1'b0, 4'h0, 3'd0, 3'd0, 3'd0, 1'b0, 3'd0, 16'h0);
        chk("R6", "then slot0", 32'(issue_tag), 32'd0);
        chk("R10", "ignored offer left r7 at 7", 32'(issue_a), 32'd7);
        chk("R5", "slot0 op", 32'(issue_op), 32'd9);
        chk("R4", "slot0 b", 32'(issue_b), 32'd2);

        finish_run();
    end

endmodule